// File: doc/BRIEF.md
# Write-Leveling Training Sequencer

This block runs a single write-leveling training pass for one DIMM over nine byte lanes: eight data lanes and the ECC lane. A pulse on `start_i` makes it latch a seed delay for every lane and the on-die-termination pattern for the target. It then raises ODT and waits for it to settle. Next it holds the training enable high for a fixed window. At the end of the window it captures the delays that the PHY found. It corrects those delays against the seeds, drops ODT, waits for settling again, and pulses `done_o`.

In pass 1 the seeds are constants that depend on the DIMM type. In pass 2 the seeds are the corrected results from the previous pass. The PHY delay field can only hold a gross value from 0 to 3. Larger seeds are therefore folded into that range when they are programmed, and the real value is rebuilt from the readback. A readback that shows the delay wrapped below zero is clamped to zero.

Top module: `wl_train_ctrl`

## Requirements
- R1: A lane byte is `{1'b0, gross[1:0], fine[4:0]}`. Lane n (0 to 3) occupies bits 8n+7:8n of `seed_lo_o`, lane n (4 to 7) occupies bits 8(n-4)+7:8(n-4) of `seed_hi_o`, and lane 8 is `seed_ecc_o`. Each word holds the programmed seeds from `start_i` acceptance onward.
- R2: The pass-1 seed (`pass2_i`=0) is gross 0 / fine 0x1A for an unbuffered DIMM. For a registered DIMM it is gross 2 / fine 0x16 when `spec_reg_i`=1, and gross 2 / fine 0 otherwise.
- R3: A seed gross of 3 or more is programmed as gross 1 if it is odd and as gross 2 if it is even. The unfolded seed is kept for correction.
- R4: When the kept seed gross is 3 or more, the result gross is the read gross plus the seed gross, minus 1 for an odd seed or minus 2 for an even seed, saturating at 7. The result fine is the read fine.
- R5: When the seed gross is 0 and the read gross is 3, the lane result is gross 0, fine 0.
- R6: In pass 2 (`pass2_i`=1) the seed is the lane's previous result, held as `{gross[2:0], fine[4:0]}`. When `spec_reg_i`=1, 0xC is first subtracted from it, saturating at 0.
- R7: The ODT pattern is a 4-bit vector. For an unbuffered target with chip selects 0 and 2 both present it is 0x3. Otherwise it has bit `dimm+2` set if the target's odd chip select (2·dimm+1) is present and the DIMM is unbuffered, and bit `dimm` set in every remaining case.
- R8: After start, `odt_en_o` is high for SETTLE_CYC cycles before `train_en_o` rises. `train_en_o` is high for exactly TRAIN_CYC cycles. ODT stays on for one capture cycle after that, then is low for SETTLE_CYC cycles before `done_o`. `train_en_o` is never high without `odt_en_o`.
- R9: `done_o` is a single-cycle pulse with ODT and training off. `lane_dly_o` (lane n in bits 8n+7:8n, `{gross[2:0], fine[4:0]}`) is valid at the pulse and changes only at capture.
- R10: `start_i` is ignored while `busy_o` is high. Pattern, seeds and sequence length are unaffected.
- R11: After reset, all outputs are 0 and every stored lane result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass (ignored while busy) |
| pass2_i | input | 1 | 0 = pass 1, 1 = pass 2 |
| dimm_i | input | 1 | Target DIMM index |
| cs_present_i | input | 4 | Chip-select present vector |
| registered_i | input | 1 | Target DIMM is registered |
| spec_reg_i | input | 1 | Special register-buffer flag |
| phy_gross_i | input | 18 | Trained gross per lane, 2 bits each |
| phy_fine_i | input | 45 | Trained fine per lane, 5 bits each |
| busy_o | output | 1 | Pass in progress |
| odt_en_o | output | 1 | Leveling ODT enable |
| odt_pat_o | output | 4 | Leveling ODT pattern |
| train_en_o | output | 1 | Training window enable |
| seed_lo_o | output | 32 | Programmed seeds, lanes 0 to 3 |
| seed_hi_o | output | 32 | Programmed seeds, lanes 4 to 7 |
| seed_ecc_o | output | 8 | Programmed seed, ECC lane |
| lane_dly_o | output | 72 | Corrected delays, 8 bits per lane |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps SETTLE_CYC at its default of 10 and shortens TRAIN_CYC to 32. The window can then be counted exactly, and many passes fit in a short run. Chaining pass-2 runs lets stored gross values climb to 3 and beyond, so both fold parities and the saturating rebuild are reached. The pass-1 unbuffered seed, with a read gross of 3, exercises the wrap-below-zero clamp.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int LANES   = 9;
  localparam int RD_GW   = 2;
  localparam int FINE_W  = 5;
  localparam int GROSS_W = 3;
  localparam int DLY_W   = GROSS_W + FINE_W;

  typedef enum logic [2:0] {
    S_IDLE, S_ODT_ON, S_TRAIN, S_CAPT, S_ODT_OFF, S_DONE
  } wl_state_e;

  // fold a wide gross into the 2-bit programmable range
  function automatic logic [RD_GW-1:0] fold_gross(logic [GROSS_W-1:0] g);
    if (g >= GROSS_W'(3)) return g[0] ? RD_GW'(1) : RD_GW'(2);
    return g[RD_GW-1:0];
  endfunction
endpackage

// File: rtl/wl_odt_map.sv
module wl_odt_map #(
  parameter int NUM_DIMMS = 2,
  localparam int DIMM_W = $clog2(NUM_DIMMS),
  localparam int CS_W   = 2 * NUM_DIMMS,
  localparam int ODT_W  = NUM_DIMMS + 2
) (
  input  logic [DIMM_W-1:0] dimm_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic              registered_i,
  output logic [ODT_W-1:0]  pat_o
);
  always_comb begin
    pat_o = '0;
    if (!registered_i && cs_i[0] && cs_i[2]) begin
      pat_o = ODT_W'(3);
    end else begin
      for (int k = 0; k < NUM_DIMMS; k++) begin
        if (int'(dimm_i) == k) begin
          if (!registered_i && cs_i[2*k+1]) pat_o[k+2] = 1'b1;
          else                              pat_o[k]   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wl_seed_gen.sv
module wl_seed_gen
  import wl_pkg::*;
#(
  parameter logic [7:0] SPEC_SUB = 8'h0C
) (
  input  logic             pass2_i,
  input  logic             registered_i,
  input  logic             spec_reg_i,
  input  logic [DLY_W-1:0] prev_i,
  output logic [DLY_W-1:0] seed_o
);
  always_comb begin
    if (!pass2_i) begin
      if (!registered_i)   seed_o = {GROSS_W'(0), FINE_W'(5'h1A)};
      else if (spec_reg_i) seed_o = {GROSS_W'(2), FINE_W'(5'h16)};
      else                 seed_o = {GROSS_W'(2), FINE_W'(0)};
    end else if (spec_reg_i) begin
      seed_o = (prev_i < SPEC_SUB) ? '0 : prev_i - SPEC_SUB;
    end else begin
      seed_o = prev_i;
    end
  end
endmodule

// File: rtl/wl_lane_fix.sv
module wl_lane_fix
  import wl_pkg::*;
(
  input  logic [DLY_W-1:0]  seed_i,
  input  logic [RD_GW-1:0]  rd_gross_i,
  input  logic [FINE_W-1:0] rd_fine_i,
  output logic [DLY_W-1:0]  dly_o
);
  logic [GROSS_W-1:0] sg;
  logic [GROSS_W:0]   sum;

  assign sg = seed_i[DLY_W-1:FINE_W];

  always_comb begin
    sum = (GROSS_W+1)'(rd_gross_i) + (GROSS_W+1)'(sg)
        - (sg[0] ? (GROSS_W+1)'(1) : (GROSS_W+1)'(2));
    if (sg >= GROSS_W'(3)) begin
      dly_o = {sum[GROSS_W] ? {GROSS_W{1'b1}} : sum[GROSS_W-1:0], rd_fine_i};
    end else if (sg == '0 && rd_gross_i == RD_GW'(3)) begin
      dly_o = '0; // wrapped below zero
    end else begin
      dly_o = {GROSS_W'(rd_gross_i), rd_fine_i};
    end
  end
endmodule

// File: rtl/wl_train_ctrl.sv
module wl_train_ctrl
  import wl_pkg::*;
#(
  parameter int NUM_DIMMS  = 2,
  parameter int SETTLE_CYC = 10,
  parameter int TRAIN_CYC  = 200,
  localparam int DIMM_W = $clog2(NUM_DIMMS),
  localparam int CS_W   = 2 * NUM_DIMMS,
  localparam int ODT_W  = NUM_DIMMS + 2,
  localparam int MAXC   = (SETTLE_CYC > TRAIN_CYC) ? SETTLE_CYC : TRAIN_CYC,
  localparam int CNT_W  = $clog2(MAXC + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     pass2_i,
  input  logic [DIMM_W-1:0]        dimm_i,
  input  logic [CS_W-1:0]          cs_present_i,
  input  logic                     registered_i,
  input  logic                     spec_reg_i,
  input  logic [LANES*RD_GW-1:0]   phy_gross_i,
  input  logic [LANES*FINE_W-1:0]  phy_fine_i,
  output logic                     busy_o,
  output logic                     odt_en_o,
  output logic [ODT_W-1:0]         odt_pat_o,
  output logic                     train_en_o,
  output logic [31:0]              seed_lo_o,
  output logic [31:0]              seed_hi_o,
  output logic [7:0]               seed_ecc_o,
  output logic [LANES*DLY_W-1:0]   lane_dly_o,
  output logic                     done_o
);
  wl_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ODT_W-1:0] pat_d, pat_q;
  logic [DLY_W-1:0] seed_q [LANES];
  logic [DLY_W-1:0] seed_d [LANES];
  logic [DLY_W-1:0] fix_d  [LANES];
  logic [DLY_W-1:0] dly_q  [LANES];

  wl_odt_map #(.NUM_DIMMS(NUM_DIMMS)) u_odt (
    .dimm_i(dimm_i), .cs_i(cs_present_i), .registered_i(registered_i), .pat_o(pat_d)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wl_seed_gen u_seed (
      .pass2_i(pass2_i), .registered_i(registered_i), .spec_reg_i(spec_reg_i),
      .prev_i(dly_q[l]), .seed_o(seed_d[l])
    );
    wl_lane_fix u_fix (
      .seed_i(seed_q[l]),
      .rd_gross_i(phy_gross_i[l*RD_GW +: RD_GW]),
      .rd_fine_i(phy_fine_i[l*FINE_W +: FINE_W]),
      .dly_o(fix_d[l])
    );
    assign lane_dly_o[l*DLY_W +: DLY_W] = dly_q[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      pat_q   <= '0;
      for (int l = 0; l < LANES; l++) begin
        seed_q[l] <= '0;
        dly_q[l]  <= '0;
      end
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_ODT_ON;
          cnt_q   <= '0;
          pat_q   <= pat_d;
          for (int l = 0; l < LANES; l++) seed_q[l] <= seed_d[l];
        end
        S_ODT_ON: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
            state_q <= S_TRAIN;
            cnt_q   <= '0;
          end
        end
        S_TRAIN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(TRAIN_CYC - 1)) state_q <= S_CAPT;
        end
        S_CAPT: begin
          for (int l = 0; l < LANES; l++) dly_q[l] <= fix_d[l];
          state_q <= S_ODT_OFF;
          cnt_q   <= '0;
        end
        S_ODT_OFF: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(SETTLE_CYC - 1)) state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign odt_en_o   = (state_q == S_ODT_ON) || (state_q == S_TRAIN) || (state_q == S_CAPT);
  assign train_en_o = (state_q == S_TRAIN);
  assign done_o     = (state_q == S_DONE);
  assign odt_pat_o  = odt_en_o ? pat_q : '0;

  always_comb begin
    seed_lo_o  = '0;
    seed_hi_o  = '0;
    seed_ecc_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (l < 4)      seed_lo_o[8*l +: 8]     = {1'b0, fold_gross(seed_q[l][DLY_W-1:FINE_W]), seed_q[l][FINE_W-1:0]};
      else if (l < 8) seed_hi_o[8*(l-4) +: 8] = {1'b0, fold_gross(seed_q[l][DLY_W-1:FINE_W]), seed_q[l][FINE_W-1:0]};
      else            seed_ecc_o              = {1'b0, fold_gross(seed_q[l][DLY_W-1:FINE_W]), seed_q[l][FINE_W-1:0]};
    end
  end
endmodule

// File: rtl/wl_train_chk.sv
module wl_train_chk #(
  parameter int TRAIN_CYC = 200,
  parameter int ODT_W = 4,
  parameter int DW = 72
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             odt_en_o,
  input logic [ODT_W-1:0] odt_pat_o,
  input logic             train_en_o,
  input logic [31:0]      seed_lo_o,
  input logic             done_o,
  input logic [DW-1:0]    lane_dly_o
);
  logic [31:0] win_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         win_q <= '0;
    else if (train_en_o) win_q <= win_q + 1;
    else                 win_q <= '0;
  end

  // R8
  train_needs_odt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_en_o |-> odt_en_o);
  // R8
  train_window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(train_en_o) |-> win_q == TRAIN_CYC);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!odt_en_o && !train_en_o && busy_o));
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(lane_dly_o));
  // R10
  busy_pat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odt_en_o && $past(odt_en_o)) |-> ($stable(odt_pat_o) && $stable(seed_lo_o)));
endmodule

bind wl_train_ctrl wl_train_chk #(
  .TRAIN_CYC(TRAIN_CYC), .ODT_W(ODT_W), .DW(wl_pkg::LANES*wl_pkg::DLY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .odt_en_o(odt_en_o),
  .odt_pat_o(odt_pat_o), .train_en_o(train_en_o), .seed_lo_o(seed_lo_o),
  .done_o(done_o), .lane_dly_o(lane_dly_o)
);

// File: tb/sim_wl_train_ctrl.sv
`timescale 1ns/1ps
module sim_wl_train_ctrl;
  localparam int S = 10;
  localparam int T = 32;
  localparam int L = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, pass2 = 0, dimm = 0, regd = 0, spec = 0;
  logic [3:0] cs = '0;
  logic [17:0] pg = '0;
  logic [44:0] pf = '0;
  logic busy, odt_en, train_en, done;
  logic [3:0] odt_pat;
  logic [31:0] slo, shi;
  logic [7:0] secc;
  logic [71:0] dly;

  int checks = 0, errors = 0;
  logic [7:0] mdl [L];

  always #4 clk = ~clk;

  wl_train_ctrl #(.SETTLE_CYC(S), .TRAIN_CYC(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pass2_i(pass2), .dimm_i(dimm),
    .cs_present_i(cs), .registered_i(regd), .spec_reg_i(spec),
    .phy_gross_i(pg), .phy_fine_i(pf), .busy_o(busy), .odt_en_o(odt_en),
    .odt_pat_o(odt_pat), .train_en_o(train_en), .seed_lo_o(slo), .seed_hi_o(shi),
    .seed_ecc_o(secc), .lane_dly_o(dly), .done_o(done)
  );

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_seed(logic [7:0] prev, logic p2, logic r, logic sp);
    if (!p2) return !r ? {3'd0, 5'h1A} : (sp ? {3'd2, 5'h16} : {3'd2, 5'h00});
    if (sp) return (prev < 8'h0C) ? 8'h00 : prev - 8'h0C;
    return prev;
  endfunction

  function automatic logic [7:0] f_pack(logic [7:0] s);
    logic [2:0] g = s[7:5];
    logic [1:0] pgv = (g >= 3) ? (g[0] ? 2'd1 : 2'd2) : g[1:0];
    return {1'b0, pgv, s[4:0]};
  endfunction

  function automatic logic [7:0] f_fix(logic [7:0] s, logic [1:0] rg, logic [4:0] rf);
    int g = int'(s[7:5]);
    int r;
    if (g >= 3) begin
      r = int'(rg) + g - ((g % 2) == 1 ? 1 : 2);
      if (r > 7) r = 7;
      return {3'(r), rf};
    end
    if (g == 0 && rg == 2'd3) return 8'h00;
    return {1'b0, rg, rf};
  endfunction

  function automatic logic [3:0] f_odt(logic d, logic [3:0] c, logic r);
    logic [3:0] p = '0;
    if (!r && c[0] && c[2]) return 4'h3;
    if (!r && c[2*d+1]) p[d+2] = 1'b1;
    else p[d] = 1'b1;
    return p;
  endfunction

  // one pass; poke = pulse start mid-training with other settings
  task automatic run_pass(logic p2, logic d, logic [3:0] c, logic r, logic sp,
                          logic [17:0] g, logic [44:0] f, logic poke);
    logic [7:0] sd [L];
    logic [7:0] ex [L];
    logic [31:0] elo = '0, ehi = '0;
    logic [3:0] epat;
    int n_train = 0, n_odt_only = 0, n_tail = 0, n_done = 0, cyc = 0;
    bit seen = 0;
    for (int l = 0; l < L; l++) begin
      sd[l] = f_seed(mdl[l], p2, r, sp);
      ex[l] = f_fix(sd[l], g[2*l +: 2], f[5*l +: 5]);
      if (l < 4) elo[8*l +: 8] = f_pack(sd[l]);
      else if (l < 8) ehi[8*(l-4) +: 8] = f_pack(sd[l]);
    end
    epat = f_odt(d, c, r);
    @(negedge clk);
    pass2 = p2; dimm = d; cs = c; regd = r; spec = sp; pg = g; pf = f; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 5000) begin
      if (train_en) begin
        n_train++;
        if (n_train == 1) begin
          chk("R7 odt pattern", 72'(odt_pat), 72'(epat));
          chk("R1/R2/R3/R6 seed_lo", 72'(slo), 72'(elo));
          chk("R1/R2/R3/R6 seed_hi", 72'(shi), 72'(ehi));
          chk("R1 seed_ecc", 72'(secc), 72'(f_pack(sd[8])));
        end
        if (poke && n_train == 3) begin
          start = 1; dimm = ~d; regd = ~r; cs = ~c; pass2 = ~p2;
        end else start = 0;
      end
      if (odt_en && !train_en) n_odt_only++;
      if (busy && !odt_en) n_tail++;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    if (cyc >= 5000) chk("R8 watchdog", 72'(0), 72'(1));
    chk("R8 train window", 72'(n_train), 72'(T));
    chk("R8 odt without train", 72'(n_odt_only), 72'(S + 1));
    chk("R8 odt-off tail", 72'(n_tail), 72'(S));
    chk("R9 done quiet", 72'({odt_en, train_en}), 72'(0));
    for (int l = 0; l < L; l++) chk("R4/R5/R9 lane result", 72'(dly[8*l +: 8]), 72'(ex[l]));
    for (int l = 0; l < L; l++) mdl[l] = ex[l];
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      n_done += int'(done);
    end
    chk("R9 done single pulse", 72'(n_done), 72'(0));
    chk("R10 idle after pass", 72'(busy), 72'(0));
    seen = 1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int l = 0; l < L; l++) mdl[l] = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {busy, odt_en, train_en, done, odt_pat}, 72'(0));
    chk("R11 reset lanes", dly, 72'(0));
    chk("R11 reset seeds", {slo, shi, secc}, 72'(0));
    rst_n = 1;
    // R2 unbuffered seed, R5 wrap clamp on every lane (read gross 3)
    run_pass(0, 0, 4'b0101, 0, 0, {L{2'd3}}, {L{5'h07}}, 0);
    // R2 registered + special, R7 odd cs present
    run_pass(0, 1, 4'b1000, 1, 1, {L{2'd3}}, {L{5'h11}}, 0);
    // R3 odd fold (seed 3), R4 rebuild: 2+3-1 = 4
    run_pass(1, 1, 4'b1000, 0, 0, {L{2'd2}}, {L{5'h09}}, 0);
    // R3 even fold (seed 4), R4: 3+4-2 = 5; R10 poke ignored
    run_pass(1, 0, 4'b0010, 0, 0, {L{2'd3}}, {L{5'h02}}, 1);
    // R6 special subtract in pass 2
    run_pass(1, 0, 4'b0001, 1, 1, {L{2'd1}}, {L{5'h1F}}, 0);
    // R2 registered non-special
    run_pass(0, 0, 4'b0011, 1, 0, {L{2'd0}}, {L{5'h04}}, 0);
    for (int i = 0; i < 24; i++) begin
      run_pass(1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
               18'($urandom), 45'({$urandom, $urandom}), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule